// File: doc/BRIEF.md
# Quad-Line PSRAM Access Engine

This block turns single-word memory requests into quad-line transactions on a pseudo-static RAM that has already been brought up in four-line command mode. A request carries an operation, a 24-bit byte address and a 32-bit write word. The engine then frames one transaction under its own chip select. Every phase moves four bits per serial beat: an 8-bit opcode, the address, dummy beats on reads only, and the data word. The data lines are shared with a flash device. That device owns the other chip-select line, and this engine never drives it active.

A second kind of request sets the device's wrapped burst length. A supported size that differs from the one already in force costs a bare command frame. The same size as the current one, an unsupported size or an undefined operation code is answered without touching the bus. The serial clock comes from a divider. The divide ratio, the extra read dummy count and a legacy hold-time selector are sampled when a request is accepted.

Top module: `qpsram_engine`

## Requirements
- R1: Operation code 0 (read) sends opcode 0xEB and then the 24-bit address. Each goes out on dq_o with dq_oe high, most significant nibble first, one nibble per serial beat.
- R2: A read then releases the data lines (dq_oe low) for 5 plus cfg_extra_dummy dummy beats. It then samples dq_i on 8 data beats and assembles resp_rdata most significant nibble first. Values on dq_i during dummy beats are never captured.
- R3: Operation code 1 (write) sends opcode 0x38 and the address, then goes straight to 8 beats that carry req_wdata, most significant nibble first, with no dummy beat.
- R4: cs_n[0] (the flash select) stays high at all times. cs_n[1] goes low in the first command beat and stays low until the hold period ends.
- R5: After the last beat, cs_n[1] stays low for 1 system clock, or for 2 system clocks when cfg_legacy_hold was set at acceptance. sclk is low and dq_oe is low during the hold.
- R6: For a ratio N of 2 or more, a counter runs from 0 to N-1 and sclk is high while the count is at or below N/2-1. A beat ends at the last high cycle, and the next nibble appears on the cycle after it. The first beat is only its high phase. A ratio of 0 or 1 gives one beat per system clock and passes the system clock to sclk during the frame.
- R7: Operation code 2 (wrap) takes the size in bytes from req_wdata. A size of 0 or 32 that differs from the size in force sends opcode 0xC0 as a bare 2-beat command, answers with resp_err low, and makes that size current. The size in force after reset is 0.
- R8: A wrap request for the size already in force gets resp_valid on the next cycle with resp_err low and no chip-select activity.
- R9: A wrap request for any size other than 0 or 32, and operation code 3, get resp_valid on the next cycle with resp_err high. There is no bus activity and the size in force does not change.
- R10: req_ready is high only while idle. resp_valid is high for exactly one cycle, the cycle in which cs_n[1] returns high. req_ready comes back on the following cycle.
- R11: During and right after reset: cs_n is 2'b11, dq_oe and sclk are low, resp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 wrap size, 3 undefined |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write word, or wrap size in bytes |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_err | output | 1 | Request rejected |
| resp_rdata | output | DATA_W | Last word read |
| cfg_ratio | input | RATIO_W | Serial clock divide ratio |
| cfg_extra_dummy | input | EXTRA_W | Extra read dummy beats |
| cfg_legacy_hold | input | 1 | Two-clock chip-select hold |
| sclk | output | 1 | Serial clock |
| cs_n | output | 2 | Chip selects, [0] flash, [1] PSRAM |
| dq_o | output | 4 | Quad data out |
| dq_oe | output | 1 | Quad data output enable |
| dq_i | input | 4 | Quad data in |

## Verification
The bench builds the engine with its default parameters: a 24-bit address, a 32-bit word, 3-bit ratio and 3-bit extra dummy fields. The ratio field therefore reaches the pass-through values 0 and 1 as well as every divided speed from 2 to 4. The extra field reaches the largest dummy window, 12 beats. A reference model expands each request into the exact per-cycle frame for the chosen ratio, dummy count and hold setting. Every cycle of chip select, serial clock, line direction, data nibbles and handshake is compared against that model. The wrap sequence walks through the size that is current after reset, a change, a repeat and the rejected sizes.

// File: rtl/qpsram_pkg.sv
package qpsram_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WRAP  = 2'd2,
    OP_UNDEF = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_HOLD,
    ST_RESP
  } st_e;

  localparam logic [7:0] OPC_QREAD  = 8'hEB;
  localparam logic [7:0] OPC_QWRITE = 8'h38;
  localparam logic [7:0] OPC_WRAP   = 8'hC0;
  localparam int         BASE_DUMMY = 5;
  localparam int         CMD_BEATS  = 2;

endpackage

// File: rtl/qpsram_clkgen.sv
module qpsram_clkgen #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               sclk,
  output logic               beat
);
  logic [RATIO_W-1:0] cnt_q, cnt_d, per_cnt, hi_cnt;
  logic               bypass, cnt_en;

  always_comb begin
    bypass  = (ratio <= RATIO_W'(1));
    per_cnt = ratio - RATIO_W'(1);
    hi_cnt  = (ratio >> 1) - RATIO_W'(1);
    cnt_en  = run | (cnt_q != '0);
    if (!run || bypass || cnt_q == per_cnt) cnt_d = '0;
    else                                    cnt_d = cnt_q + RATIO_W'(1);
    beat = run & (bypass | (cnt_q == hi_cnt));
    sclk = run & (bypass ? clk : (cnt_q <= hi_cnt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qpsram_shift.sv
module qpsram_shift #(
  parameter int SH_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_hdr,
  input  logic [SH_W-1:0]   hdr,
  input  logic              load_wd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              shift_out,
  input  logic              shift_in,
  input  logic [3:0]        dq_i,
  output logic [3:0]        dq_o,
  output logic [DATA_W-1:0] rdata
);
  logic [SH_W-1:0]   osh_q, osh_d;
  logic [DATA_W-1:0] ish_q, ish_d;
  logic              osh_en;

  always_comb begin
    osh_en = load_hdr | load_wd | shift_out;
    if (load_wd)       osh_d = SH_W'(wdata) << (SH_W - DATA_W);
    else if (load_hdr) osh_d = hdr;
    else               osh_d = osh_q << 4;
    ish_d = {ish_q[DATA_W-5:0], dq_i};
    dq_o  = osh_q[SH_W-1 -: 4];
    rdata = ish_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      osh_q <= '0;
    else if (osh_en) osh_q <= osh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ish_q <= '0;
    else if (shift_in) ish_q <= ish_d;
  end
endmodule

// File: rtl/qpsram_seq.sv
module qpsram_seq
  import qpsram_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int RATIO_W = 3,
  parameter int EXTRA_W = 3,
  parameter int SH_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [EXTRA_W-1:0] cfg_extra,
  input  logic               cfg_legacy,
  input  logic               beat,
  output logic               req_ready,
  output logic               resp_valid,
  output logic               resp_err,
  output logic               run,
  output logic               cs_act,
  output logic               oe,
  output logic               load_hdr,
  output logic [SH_W-1:0]    hdr,
  output logic               load_wd,
  output logic               shift_out,
  output logic               shift_in,
  output logic [RATIO_W-1:0] ratio_q
);
  localparam int ADDR_BEATS = ADDR_W / 4;
  localparam int DATA_BEATS = DATA_W / 4;
  localparam int MAX_DUMMY  = BASE_DUMMY + (1 << EXTRA_W) - 1;
  localparam int PH_MAX_AD  = (ADDR_BEATS > DATA_BEATS) ? ADDR_BEATS : DATA_BEATS;
  localparam int PH_MAX     = (MAX_DUMMY > PH_MAX_AD) ? MAX_DUMMY : PH_MAX_AD;
  localparam int PH_W       = $clog2(PH_MAX + 1);

  st_e                st_q, st_d;
  op_e                op_q, op_d;
  logic [PH_W-1:0]    ph_q, ph_d, ph_last, dummy_last, hold_last;
  logic               err_q, err_d, wrap32_q, wrap32_d, tgt_q;
  logic [EXTRA_W-1:0] extra_q;
  logic               legacy_q, accept, phase_end, w0, w32;
  logic [7:0]         opc;

  always_comb begin
    accept     = (st_q == ST_IDLE) & req_valid;
    w0         = (req_wdata == '0);
    w32        = (req_wdata == DATA_W'(32));
    dummy_last = PH_W'(BASE_DUMMY - 1) + PH_W'(extra_q);
    hold_last  = legacy_q ? PH_W'(1) : PH_W'(0);
    case (st_q)
      ST_CMD:   ph_last = PH_W'(CMD_BEATS - 1);
      ST_ADDR:  ph_last = PH_W'(ADDR_BEATS - 1);
      ST_DUMMY: ph_last = dummy_last;
      ST_DATA:  ph_last = PH_W'(DATA_BEATS - 1);
      default:  ph_last = '0;
    endcase
    phase_end = beat & (ph_q == ph_last);
    case (op_e'(req_op))
      OP_READ:  opc = OPC_QREAD;
      OP_WRITE: opc = OPC_QWRITE;
      default:  opc = OPC_WRAP;
    endcase
    hdr = (op_e'(req_op) == OP_WRAP) ? (SH_W'({opc, {ADDR_W{1'b0}}}) << (SH_W - 8 - ADDR_W))
                                     : (SH_W'({opc, req_addr}) << (SH_W - 8 - ADDR_W));
  end

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    ph_d     = ph_q;
    err_d    = err_q;
    wrap32_d = wrap32_q;
    load_hdr = 1'b0;
    load_wd  = 1'b0;
    if (beat) ph_d = phase_end ? '0 : ph_q + PH_W'(1);
    case (st_q)
      ST_IDLE: if (accept) begin
        op_d  = op_e'(req_op);
        ph_d  = '0;
        err_d = 1'b0;
        case (op_e'(req_op))
          OP_READ, OP_WRITE: begin st_d = ST_CMD; load_hdr = 1'b1; end
          OP_WRAP: begin
            if (!(w0 | w32))          begin st_d = ST_RESP; err_d = 1'b1; end
            else if (w32 == wrap32_q) st_d = ST_RESP;
            else                      begin st_d = ST_CMD; load_hdr = 1'b1; end
          end
          default: begin st_d = ST_RESP; err_d = 1'b1; end
        endcase
      end
      ST_CMD:   if (phase_end) st_d = (op_q == OP_WRAP) ? ST_HOLD : ST_ADDR;
      ST_ADDR:  if (phase_end) begin
        st_d    = (op_q == OP_READ) ? ST_DUMMY : ST_DATA;
        load_wd = (op_q != OP_READ);
      end
      ST_DUMMY: if (phase_end) st_d = ST_DATA;
      ST_DATA:  if (phase_end) st_d = ST_HOLD;
      ST_HOLD: begin
        if (ph_q == hold_last) begin
          st_d = ST_RESP;
          ph_d = '0;
          if (op_q == OP_WRAP) wrap32_d = tgt_q;
        end else begin
          ph_d = ph_q + PH_W'(1);
        end
      end
      ST_RESP:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    run        = (st_q == ST_CMD) | (st_q == ST_ADDR) | (st_q == ST_DUMMY) | (st_q == ST_DATA);
    cs_act     = run | (st_q == ST_HOLD);
    oe         = (st_q == ST_CMD) | (st_q == ST_ADDR) | ((st_q == ST_DATA) & (op_q == OP_WRITE));
    shift_out  = beat & oe;
    shift_in   = beat & (st_q == ST_DATA) & (op_q == OP_READ);
    req_ready  = (st_q == ST_IDLE);
    resp_valid = (st_q == ST_RESP);
    resp_err   = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_READ;
      ph_q     <= '0;
      err_q    <= 1'b0;
      wrap32_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      op_q     <= op_d;
      ph_q     <= ph_d;
      err_q    <= err_d;
      wrap32_q <= wrap32_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q  <= '0;
      extra_q  <= '0;
      legacy_q <= 1'b0;
      tgt_q    <= 1'b0;
    end else if (accept) begin
      ratio_q  <= cfg_ratio;
      extra_q  <= cfg_extra;
      legacy_q <= cfg_legacy;
      tgt_q    <= w32;
    end
  end
endmodule

// File: rtl/qpsram_engine.sv
module qpsram_engine #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int RATIO_W = 3,
  parameter int EXTRA_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               resp_valid,
  output logic               resp_err,
  output logic [DATA_W-1:0]  resp_rdata,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [EXTRA_W-1:0] cfg_extra_dummy,
  input  logic               cfg_legacy_hold,
  output logic               sclk,
  output logic [1:0]         cs_n,
  output logic [3:0]         dq_o,
  output logic               dq_oe,
  input  logic [3:0]         dq_i
);
  localparam int HDR_W = 8 + ADDR_W;
  localparam int SH_W  = (DATA_W > HDR_W) ? DATA_W : HDR_W;

  logic [1:0]         rs_q;
  logic               rst_ni, run, cs_act, beat, load_hdr, load_wd, shift_out, shift_in;
  logic [SH_W-1:0]    hdr;
  logic [RATIO_W-1:0] ratio_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  qpsram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_W(RATIO_W), .EXTRA_W(EXTRA_W), .SH_W(SH_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_ni), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_ratio(cfg_ratio),
    .cfg_extra(cfg_extra_dummy), .cfg_legacy(cfg_legacy_hold), .beat(beat),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_err(resp_err),
    .run(run), .cs_act(cs_act), .oe(dq_oe), .load_hdr(load_hdr), .hdr(hdr),
    .load_wd(load_wd), .shift_out(shift_out), .shift_in(shift_in), .ratio_q(ratio_q)
  );

  qpsram_clkgen #(.RATIO_W(RATIO_W)) u_clk (
    .clk(clk), .rst_n(rst_ni), .run(run), .ratio(ratio_q), .sclk(sclk), .beat(beat)
  );

  qpsram_shift #(.SH_W(SH_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_ni), .load_hdr(load_hdr), .hdr(hdr), .load_wd(load_wd),
    .wdata(req_wdata), .shift_out(shift_out), .shift_in(shift_in), .dq_i(dq_i),
    .dq_o(dq_o), .rdata(resp_rdata)
  );

  assign cs_n = {~cs_act, 1'b1};
endmodule

// File: rtl/qpsram_checker.sv
module qpsram_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       resp_valid,
  input logic       sclk,
  input logic [1:0] cs_n,
  input logic       dq_oe
);
  // R6: serial clock parked while the PSRAM is deselected
  assert_sclk_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n[1] |-> !sclk);
  // R4: lines driven only inside a frame
  assert_oe_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !cs_n[1]);
  // R10: completion cycle is deselected and busy
  assert_resp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (cs_n[1] && !req_ready));
  // R10: chip-select release coincides with completion
  assert_release_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n[1]) |-> resp_valid);
  // R10: an accepted request makes the engine busy
  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R10: completion strobe lasts one cycle
  assert_resp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
endmodule

bind qpsram_engine qpsram_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .sclk(sclk), .cs_n(cs_n), .dq_oe(dq_oe)
);

// File: tb/qpsram_engine_test.sv
module qpsram_engine_test;
  localparam int ADDR_W = 24, DATA_W = 32, RATIO_W = 3, EXTRA_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, resp_valid, resp_err, cfg_legacy_hold, sclk, dq_oe;
  logic [1:0] req_op, cs_n;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, resp_rdata;
  logic [RATIO_W-1:0] cfg_ratio;
  logic [EXTRA_W-1:0] cfg_extra_dummy;
  logic [3:0] dq_o, dq_i;

  always #2 clk = ~clk;

  qpsram_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_W(RATIO_W), .EXTRA_W(EXTRA_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_err(resp_err),
    .resp_rdata(resp_rdata), .cfg_ratio(cfg_ratio), .cfg_extra_dummy(cfg_extra_dummy),
    .cfg_legacy_hold(cfg_legacy_hold), .sclk(sclk), .cs_n(cs_n), .dq_o(dq_o), .dq_oe(dq_oe),
    .dq_i(dq_i));

  typedef struct {
    bit cs1; bit sclk; bit oe; bit [3:0] dq; bit rdy; bit rv; bit err;
    bit chk_rd; bit [31:0] rd; bit [3:0] din; int tag;
  } exp_t;

  exp_t q[$];
  int vecs = 0, bad = 0;
  bit wrap32_m = 1'b0;
  bit done = 1'b0;

  function automatic string rq(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      11: return "R11";
      default: return "R10";
    endcase
  endfunction

  function automatic exp_t idle_e(int tag);
    exp_t e = '{default: 0};
    e.rdy = 1'b1;
    e.tag = tag;
    return e;
  endfunction

  task automatic fail(string r, string what, int act, int expv);
    bad++;
    $display("FAIL %s %s actual %0h expected %0h at %0t", r, what, act, expv, $time);
  endtask

  task automatic step(int idle_tag);
    exp_t e;
    @(negedge clk);
    e = (q.size() != 0) ? q.pop_front() : idle_e(idle_tag);
    dq_i = e.din;
    vecs++;
    if (cs_n !== {~e.cs1, 1'b1}) fail("R4/R5", "cs_n", int'(cs_n), int'({~e.cs1, 1'b1}));
    if (sclk !== e.sclk) fail("R6", "sclk", int'(sclk), int'(e.sclk));
    if (dq_oe !== e.oe) fail(rq(e.tag), "dq_oe", int'(dq_oe), int'(e.oe));
    if (e.oe && dq_o !== e.dq) fail(rq(e.tag), "dq_o", int'(dq_o), int'(e.dq));
    if (req_ready !== e.rdy) fail("R10", "req_ready", int'(req_ready), int'(e.rdy));
    if (resp_valid !== e.rv) fail("R10", "resp_valid", int'(resp_valid), int'(e.rv));
    if (e.rv && resp_err !== e.err) fail(rq(e.tag), "resp_err", int'(resp_err), int'(e.err));
    if (e.chk_rd && resp_rdata !== e.rd) fail("R2", "resp_rdata", int'(resp_rdata), int'(e.rd));
  endtask

  task automatic push_bus(int op, bit [23:0] a, bit [31:0] wd, bit [31:0] rw,
                          int ratio, int extra, bit legacy, int tag);
    bit [3:0] bn[$];
    bit bo[$];
    bit [3:0] bd[$];
    bit [7:0] opc;
    exp_t e;
    int n, h;
    opc = (op == 0) ? 8'hEB : (op == 1) ? 8'h38 : 8'hC0;
    for (int k = 1; k >= 0; k--) begin bn.push_back(opc[4*k +: 4]); bo.push_back(1); bd.push_back(0); end
    if (op != 2)
      for (int k = 5; k >= 0; k--) begin bn.push_back(a[4*k +: 4]); bo.push_back(1); bd.push_back(0); end
    if (op == 0) begin
      for (int k = 0; k < 5 + extra; k++) begin bn.push_back(0); bo.push_back(0); bd.push_back(4'hA); end
      for (int k = 7; k >= 0; k--) begin bn.push_back(0); bo.push_back(0); bd.push_back(rw[4*k +: 4]); end
    end else if (op == 1) begin
      for (int k = 7; k >= 0; k--) begin bn.push_back(wd[4*k +: 4]); bo.push_back(1); bd.push_back(0); end
    end
    n = (ratio <= 1) ? 1 : ratio;
    h = n / 2 - 1;
    for (int i = 0; i < bn.size(); i++) begin
      e = '{default: 0};
      e.cs1 = 1'b1; e.oe = bo[i]; e.dq = bn[i]; e.din = bd[i]; e.tag = tag;
      if (n == 1) q.push_back(e);
      else begin
        if (i > 0) begin e.sclk = 1'b0; repeat (n - 1 - h) q.push_back(e); end
        e.sclk = 1'b1;
        repeat (h + 1) q.push_back(e);
      end
    end
    e = '{default: 0};
    e.cs1 = 1'b1; e.tag = tag;
    repeat (legacy ? 2 : 1) q.push_back(e);
    e = '{default: 0};
    e.rv = 1'b1; e.chk_rd = (op == 0); e.rd = rw; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_resp(bit err, int tag);
    exp_t e = '{default: 0};
    e.rv = 1'b1; e.err = err; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic run_op(int op, bit [23:0] a, bit [31:0] wd, bit [31:0] rw,
                        int ratio, int extra, bit legacy, int tag);
    cfg_ratio = RATIO_W'(ratio);
    cfg_extra_dummy = EXTRA_W'(extra);
    cfg_legacy_hold = legacy;
    req_op = op[1:0]; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    if (op == 2) begin
      if (wd != 0 && wd != 32) push_resp(1'b1, 9);
      else if ((wd == 32) == wrap32_m) push_resp(1'b0, 8);
      else begin push_bus(2, a, wd, rw, ratio, extra, legacy, 7); wrap32_m = (wd == 32); end
    end else if (op == 3) push_resp(1'b1, 9);
    else push_bus(op, a, wd, rw, ratio, extra, legacy, tag);
    step(10);
    req_valid = 1'b0;
    while (q.size() != 0) step(10);
    step(10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_wdata = '0;
    cfg_ratio = '0; cfg_extra_dummy = '0; cfg_legacy_hold = 1'b0; dq_i = 4'h0;
    step(11);
    step(11);
    rst_n = 1'b1;
    repeat (3) step(11);
    // R1, R2, R6: read with pass-through clock
    run_op(0, 24'h123456, 32'h0, 32'hDEADBEEF, 1, 0, 1'b0, 1);
    // R3, R6: write at ratio 2
    run_op(1, 24'hABCDEF, 32'h01234567, 32'h0, 2, 0, 1'b0, 3);
    // R2, R5, R6: read at ratio 3, extra dummy, legacy hold
    run_op(0, 24'h00F00D, 32'h0, 32'h5A5AC3C3, 3, 2, 1'b1, 1);
    // R3, R5: write at ratio 4 with legacy hold
    run_op(1, 24'hFEDCBA, 32'h89ABCDEF, 32'h0, 4, 0, 1'b1, 3);
    // R2: largest dummy window, ratio 0 passes clock
    run_op(0, 24'h000001, 32'h0, 32'h13579BDF, 0, 7, 1'b0, 1);
    // R8: size 0 is in force after reset
    run_op(2, 24'h0, 32'd0, 32'h0, 2, 0, 1'b0, 8);
    // R9: unsupported sizes and undefined operation
    run_op(2, 24'h0, 32'd16, 32'h0, 2, 0, 1'b0, 9);
    run_op(2, 24'h0, 32'd64, 32'h0, 2, 0, 1'b0, 9);
    run_op(3, 24'h0, 32'd32, 32'h0, 2, 0, 1'b0, 9);
    // R7: change to 32, then repeat (R8), then back to 0 (R7)
    run_op(2, 24'h0, 32'd32, 32'h0, 2, 0, 1'b0, 7);
    run_op(2, 24'h0, 32'd32, 32'h0, 4, 0, 1'b0, 8);
    run_op(2, 24'h0, 32'd0, 32'h0, 3, 0, 1'b1, 7);
    // R1, R2: ratio 4 read after wrap traffic
    run_op(0, 24'h7FFFFF, 32'h0, 32'hF0E1D2C3, 4, 1, 1'b0, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule